// File: doc/BRIEF.md
# Countdown-Signalling Pipelined Bus Slave

This block is a memory-mapped slave for an on-chip processor bus. It does not answer with a single ready or wait bit. Instead it drives a small down-counter, `eta_cnt`, that tells the master how many cycles remain until the result of its latest command is available. A master can use this early notice to restart its own pipeline ahead of time. A simpler master can ignore the count and wait for zero.

The master pulses a read or a write strobe for one cycle, together with the address and the write data. The slave captures all of these on the accepting edge, so the master may change them on the very next cycle. Behind the port sits a small register file whose latency depends on the access pattern. The first access to an address costs a longer latency. An access to the address right after the previously accepted one costs a shorter latency. Read data stays on `rsp_data` until a later read completes.

Flow control follows valid/ready conventions, with one difference. The strobes act as the valid signal and `req_ready` acts as ready, but a command that is offered while `req_ready` is low is dropped, not held. The master must wait for `req_ready` and then present the command again. Results always complete in the order in which the commands were accepted.

Top module: `cdn_slave`

## Requirements
- R1: After reset, `eta_cnt` is 0, `rsp_data` is 0, `req_ready` is 1, and every storage word reads as 0.
- R2: A command is sampled on the single edge where a strobe is high and `req_ready` is 1. The address and write data may change in the very next cycle without affecting the result.
- R3: `eta_cnt` is 2 bits wide and gives the number of cycles until the result is valid. It is 0 in the cycle the result is valid and also when the slave is idle. It is capped at 3 and falls by one each cycle. With the first-access latency at 4, the cycles after acceptance show 3, 2, 1, 0.
- R4: `req_ready` is 1 exactly when `eta_cnt` is 0 or 1. A strobe offered while `req_ready` is 0 is dropped. It has no effect on the count, the stored words, `rsp_data` or the sequential-address tracking.
- R5: A command takes FIRST_LAT cycles, unless its address equals the previously accepted address plus one (modulo 2^AW). In that case it takes SEQ_LAT cycles. The first command after reset is never sequential. Both reads and writes count as accepted addresses.
- R6: `rsp_data` changes only when a read completes, and then holds its value. Completing writes and idle cycles leave it unchanged.
- R7: Suppose a command is accepted while `eta_cnt` is 1. The previous result is valid in the next cycle, and from then on the count refers to the new command. The new result is never delivered in the same cycle as the previous one, so a latency of 1 becomes a count of 1 there.
- R8: A write stores its data when its count reaches 0, and later reads return that data. When both strobes are high in the same cycle, the command is a read and the write is dropped.
- R9: With SEQ_LAT at 1, a sequential read accepted while idle shows count 0 and its data in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rd | input | 1 | Read strobe, one cycle per command |
| req_wr | input | 1 | Write strobe, one cycle per command |
| req_addr | input | AW | Word address of the command |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | A strobe in this cycle will be accepted |
| eta_cnt | output | CW | Cycles until the latest result is valid, capped |
| rsp_data | output | DW | Data of the last completed read, held |

## Verification
On every cycle, the embedded assertions check the following:
- A count of 2 always steps to 1, and a capped count never falls by more than one.
- An ignored strobe can never raise the count.
- `rsp_data` cannot move while the count is 2 or more.
- Reset leaves the count and the data at zero.

The bench scenarios are needed for the behaviours that depend on data and history: the latency choice between sequential and first accesses (including address wrap), write-then-read data, the dropped write while busy, the read-wins rule for double strobes, and the handover when a command is accepted at count 1.

// File: rtl/cdn_pkg.sv
package cdn_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // a read strobe wins over a write strobe in the same cycle
  function automatic op_e decode_op(input logic rd, input logic wr);
    if (rd) return OP_READ;
    if (wr) return OP_WRITE;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/cdn_capture.sv
module cdn_capture
  import cdn_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  output logic          take,
  output op_e           take_op,
  output logic          seq_hit,
  output op_e           held_op,
  output logic [AW-1:0] held_addr,
  output logic [DW-1:0] held_data
);
  logic have_prev;

  assign take    = ready && (req_rd || req_wr);
  assign take_op = decode_op(req_rd, req_wr);
  assign seq_hit = have_prev && (req_addr == AW'(held_addr + 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      held_op   <= OP_IDLE;
      held_addr <= '0;
      held_data <= '0;
    end else if (take) begin
      have_prev <= 1'b1;
      held_op   <= take_op;
      held_addr <= req_addr;
      held_data <= req_wdata;
    end
  end
endmodule

// File: rtl/cdn_timer.sv
module cdn_timer #(
  parameter int FIRST_LAT = 4,
  parameter int SEQ_LAT   = 1,
  parameter int CW        = 2,
  parameter int RW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          seq_hit,
  output logic          ready,
  output logic [CW-1:0] eta,
  output logic          fire_held,
  output logic          fire_now
);
  localparam int CMAX = (1 << CW) - 1;

  logic [RW-1:0] rem, rem_nxt, lat_sel;

  assign lat_sel = seq_hit ? RW'(SEQ_LAT) : RW'(FIRST_LAT);
  assign ready   = (rem <= RW'(1));
  assign eta     = (rem > RW'(CMAX)) ? CW'(CMAX) : rem[CW-1:0];
  assign fire_held = (rem == RW'(1));

  always_comb begin
    rem_nxt  = rem;
    fire_now = 1'b0;
    if (take) begin
      if (lat_sel == RW'(1)) begin
        if (rem == RW'(1)) begin
          rem_nxt = RW'(1);          // keep results in separate cycles
        end else begin
          rem_nxt  = '0;
          fire_now = 1'b1;
        end
      end else begin
        rem_nxt = lat_sel - RW'(1);
      end
    end else if (rem != '0) begin
      rem_nxt = rem - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem <= '0;
    else        rem <= rem_nxt;
  end

  // R3: a count of two always steps to one
  a_r3_two_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eta == CW'(2)) |=> (eta == CW'(1)));
  // R3: a capped count descends by at most one
  a_r3_cap_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (eta == CW'(CMAX)) |=> (eta >= CW'(CMAX - 1)));
  // R7: completions never coincide
  a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_held && fire_now));
endmodule

// File: rtl/cdn_store.sv
module cdn_store
  import cdn_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (fire) begin
      if (op == OP_READ)  rdata     <= mem[addr];
      if (op == OP_WRITE) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/cdn_slave.sv
module cdn_slave
  import cdn_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int CW        = 2,
  parameter int FIRST_LAT = 4,
  parameter int SEQ_LAT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [CW-1:0] eta_cnt,
  output logic [DW-1:0] rsp_data
);
  localparam int LMAX   = (FIRST_LAT > SEQ_LAT) ? FIRST_LAT : SEQ_LAT;
  localparam int RW_RAW = $clog2(LMAX + 1);
  localparam int RW     = (RW_RAW > CW) ? RW_RAW : CW;

  logic          take, seq_hit, fire_held, fire_now;
  op_e           take_op, held_op, eff_op;
  logic [AW-1:0] held_addr, eff_addr;
  logic [DW-1:0] held_data, eff_data;

  cdn_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(req_ready),
    .take(take), .take_op(take_op), .seq_hit(seq_hit),
    .held_op(held_op), .held_addr(held_addr), .held_data(held_data)
  );

  cdn_timer #(.FIRST_LAT(FIRST_LAT), .SEQ_LAT(SEQ_LAT), .CW(CW), .RW(RW)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(take), .seq_hit(seq_hit),
    .ready(req_ready), .eta(eta_cnt),
    .fire_held(fire_held), .fire_now(fire_now)
  );

  // single-cycle latency completes straight from the port
  assign eff_op   = fire_now ? take_op   : held_op;
  assign eff_addr = fire_now ? req_addr  : held_addr;
  assign eff_data = fire_now ? req_wdata : held_data;

  cdn_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .fire(fire_held || fire_now),
    .op(eff_op), .addr(eff_addr), .wdata(eff_data), .rdata(rsp_data)
  );

  // R1: clean state right after reset release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (eta_cnt == '0 && rsp_data == '0));
  // R4: a strobe while not ready can never raise the count
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (eta_cnt <= $past(eta_cnt)));
  // R6: read data cannot move while the count is two or more
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (eta_cnt >= CW'(2)) |=> $stable(rsp_data));
endmodule

// File: tb/tb_cdn_slave.sv
module tb_cdn_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int FIRST = 4;
  localparam int SEQ = 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_rd = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready;
  logic [1:0] eta_cnt;
  logic [DW-1:0] rsp_data;

  cdn_slave #(.AW(AW), .DW(DW), .CW(2), .FIRST_LAT(FIRST), .SEQ_LAT(SEQ)) dut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .eta_cnt(eta_cnt), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  int mem_m [DEPTH];
  int rd_m = 0;
  int last_m = 0;
  bit have_m = 1'b0;

  function automatic int sat3(input int k);
    return (k > 3) ? 3 : k;
  endfunction

  function automatic int lat_of(input int a);
    return (have_m && a == ((last_m + 1) % DEPTH)) ? SEQ : FIRST;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input bit rd, input bit wr, input int a, input int d);
    if (rd) rd_m = mem_m[a];
    else if (wr) mem_m[a] = d;
  endtask

  // present for one cycle, then scramble inputs (R2)
  task automatic drive(input bit rd, input bit wr, input int a, input int d);
    req_rd = rd; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0; req_addr = ~AW'(a); req_wdata = ~DW'(d);
  endtask

  task automatic txn(input bit rd, input bit wr, input int a, input int d);
    int lat;
    lat = lat_of(a);
    have_m = 1'b1; last_m = a;
    drive(rd, wr, a, d);
    for (int k = lat - 1; k >= 0; k--) begin
      chk("R3/R5 count", eta_cnt, sat3(k));
      chk("R4 ready", req_ready, (k <= 1) ? 1 : 0);
      if (k == 0) model(rd, wr, a, d);
      chk("R6/R8 data (R2 captured)", rsp_data, rd_m);
      if (k > 0) @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 count", eta_cnt, 0);
    chk("R1 data", rsp_data, 0);
    chk("R1 ready", req_ready, 1);

    // directed: writes then reads, sequential and first-access latency (R5, R8, R9)
    txn(0, 1, 5, 16'h1234);
    txn(0, 1, 6, 16'hBEEF);
    txn(1, 0, 5, 0);
    txn(1, 0, 6, 0);          // R9 sequential read, data next cycle
    chk("R9 early data", rsp_data, 16'hBEEF);
    txn(0, 1, 7, 16'h0777);   // R6 write leaves data alone
    chk("R6 hold after write", rsp_data, 16'hBEEF);

    // R4: write offered while busy is dropped
    have_m = 1'b1; last_m = 2;
    drive(1, 0, 2, 0);
    chk("R4 busy count", eta_cnt, 3);
    req_wr = 1'b1; req_addr = 2; req_wdata = 16'hDEAD;
    @(negedge clk);
    chk("R4 ignored count", eta_cnt, 2);
    chk("R4 ready low", req_ready, 0);
    @(negedge clk);
    req_wr = 1'b0;
    chk("R4 ignored count 1", eta_cnt, 1);
    @(negedge clk);
    model(1, 0, 2, 0);
    chk("R4 count 0", eta_cnt, 0);
    chk("R4 read data", rsp_data, rd_m);
    txn(1, 0, 2, 0);          // no seq credit, old content
    chk("R4 write dropped", rsp_data, 0);

    // R7: accept at count 1 with a one-cycle follower
    txn(0, 1, 9, 16'h0099);
    txn(0, 1, 10, 16'h00AA);
    drive(1, 0, 9, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 count before", eta_cnt, 1);
    req_rd = 1'b1; req_addr = 10;
    @(negedge clk);
    req_rd = 1'b0; req_addr = 0;
    chk("R7 previous data", rsp_data, 16'h0099);
    chk("R7 count new", eta_cnt, 1);
    @(negedge clk);
    chk("R7 new count 0", eta_cnt, 0);
    chk("R7 new data", rsp_data, 16'h00AA);
    last_m = 10; rd_m = 16'h00AA;

    // R8: both strobes act as a read
    txn(1, 1, 9, 16'h5555);
    chk("R8 both read", rsp_data, 16'h0099);
    txn(1, 0, 9, 0);
    chk("R8 write dropped", rsp_data, 16'h0099);

    // R5: address wrap counts as sequential
    txn(0, 1, 15, 16'h0F0F);
    txn(1, 0, 0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, a, d;
      op = $urandom % 3;
      a = ($urandom % 2) ? (last_m + 1) % DEPTH : $urandom % DEPTH;
      d = $urandom & 16'hFFFF;
      txn(op != 1, op != 0, a, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule